// File: doc/BRIEF.md
# Privilege Access Filter

This block sits in the external address decode of a processor that supports user, supervisor and machine modes. Each bus cycle arrives with an address, a read strobe, a write strobe and the two-bit privilege mode of the code that issued it. Within the same cycle the filter decides whether the reference may reach one of the guarded devices. A granted access raises that device's select line, and also the shared write enable when the cycle is a write. A refused access raises a deny flag, which the bus turns into a fault, and drives no select and no write enable.

Two regions are guarded. The first is a RAM bank placed inside ROM space, in the way a ROM emulator uses it. Code in any mode may read it, but only supervisor and machine code may write it. The second is a power-control register that only machine code may read or write. The base, size and rights of each region are parameters. An address in neither region passes through untouched: no select and no deny. A region whose size is a power of two and whose base is aligned to that size is matched by a masked compare. Any other region is matched by a full range compare.

Top module: `priv_access_filter`

## Requirements
- R1: `priv_mode` is decoded as 2'b00 user, 2'b01 supervisor, 2'b11 machine, and the reserved value 2'b10 is given exactly the rights of user.
- R2: A read anywhere in the RAM bank is granted in every mode: `ram_sel` is 1 and `bus_deny` is 0 in the same cycle as the strobe.
- R3: A write to the RAM bank from supervisor or machine mode raises `ram_sel` and `dev_we` in the same cycle.
- R4: A write to the RAM bank from user mode raises `bus_deny` and leaves `ram_sel` and `dev_we` at 0, so a later read from a permitted mode returns the data held before the refused write.
- R5: Reads and writes to the power-control register from machine mode are granted: `pwr_sel` is 1, `dev_we` follows the write strobe, and `bus_deny` is 0.
- R6: Any read or write to the power-control register from user or supervisor mode raises `bus_deny` with `pwr_sel` and `dev_we` at 0, and leaves the register contents unchanged.
- R7: An access to an address outside both regions drives no select, no write enable and no deny.
- R8: With neither strobe active, all four outputs are 0 whatever the address and mode are.
- R9: When both strobes are active together, the cycle is judged by the write rights of the region and `dev_we` is raised if the access is granted.
- R10: At most one select is active in any cycle, `dev_we` is never 1 without a select and the write strobe, and `bus_deny` is never 1 together with a select.
- R11: The first and last byte addresses of each region are inside it, and the byte just below the base and the byte just past the end are outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used only to sample the built-in property checks |
| rst_n | input | 1 | Active-low reset that disables the property checks |
| addr | input | ADDR_W | Byte address of the current bus cycle |
| rd_stb | input | 1 | Read strobe of the current cycle |
| wr_stb | input | 1 | Write strobe of the current cycle |
| priv_mode | input | 2 | Privilege mode attached to the cycle |
| ram_sel | output | 1 | Select for the RAM bank in ROM space |
| pwr_sel | output | 1 | Select for the power-control register |
| dev_we | output | 1 | Write enable to whichever device is selected |
| bus_deny | output | 1 | Access refused, report a bus fault |

## Verification
The properties assume that address, strobes and mode are settled at each rising edge and stay constant for the whole bus cycle, because the outputs are purely combinational. They also assume that the two regions never overlap, which is checked at elaboration. The stimulus changes inputs only just after a rising edge, and it takes addresses from region boundaries, region interiors and the gaps between them. For the reserved mode value the properties expect user rights, and the stimulus drives that value as often as the three legal ones.

// File: rtl/privfilt_pkg.sv
package privfilt_pkg;

   typedef enum logic [1:0] {
      LVL_USER    = 2'd0,
      LVL_SUPER   = 2'd1,
      LVL_MACHINE = 2'd2
   } priv_lvl_e;

   // Bus mode code to an ordered privilege level; reserved 2'b10 ranks as user (R1)
   function automatic priv_lvl_e mode_to_level(input logic [1:0] mode);
      priv_lvl_e lvl;
      case (mode)
         2'b01:   lvl = LVL_SUPER;
         2'b11:   lvl = LVL_MACHINE;
         default: lvl = LVL_USER;
      endcase
      return lvl;
   endfunction

endpackage

// File: rtl/pf_region_match.sv
module pf_region_match #(
   parameter int unsigned        ADDR_W = 24,
   parameter logic [ADDR_W-1:0] BASE   = '0,
   parameter logic [ADDR_W-1:0] SIZE   = ADDR_W'(16)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] LOW_MSK = SIZE - ONE_A;
   localparam logic [ADDR_W:0]   END_X   = {1'b0, BASE} + {1'b0, SIZE};
   localparam logic [ADDR_W:0]   SPACE   = {1'b1, {ADDR_W{1'b0}}};
   localparam bit                IS_POW2 = ((SIZE & LOW_MSK) == '0);
   localparam bit                ALIGNED = ((BASE & LOW_MSK) == '0);

   // elaboration-time parameter checks
   if (ADDR_W < 2) begin : g_bad_width
      $error("pf_region_match: ADDR_W must be at least 2");
   end
   if (SIZE == '0) begin : g_bad_size
      $error("pf_region_match: region size must be non-zero");
   end
   if (END_X > SPACE) begin : g_bad_end
      $error("pf_region_match: region runs past the top of the address space");
   end

   if (IS_POW2 && ALIGNED) begin : g_mask
      // aligned power-of-two window: compare only the upper address bits
      localparam logic [ADDR_W-1:0] HI_MSK = ~LOW_MSK;
      assign hit = ((addr & HI_MSK) == BASE);
   end else begin : g_range
      // arbitrary window: two magnitude compares on one extra bit
      logic [ADDR_W:0] addr_x;
      assign addr_x = {1'b0, addr};
      assign hit    = (addr_x >= {1'b0, BASE}) && (addr_x < END_X);
   end

endmodule

// File: rtl/pf_rights_check.sv
module pf_rights_check
   import privfilt_pkg::*;
#(
   parameter priv_lvl_e RD_NEED = LVL_USER,
   parameter priv_lvl_e WR_NEED = LVL_MACHINE
) (
   input  priv_lvl_e lvl,
   input  logic      hit,
   input  logic      rd,
   input  logic      wr,
   output logic      grant,
   output logic      refuse
);

   logic      active;
   priv_lvl_e need;
   logic      enough;

   // a cycle that carries both strobes is judged by write rights (R9)
   assign active = hit && (rd || wr);
   assign need   = wr ? WR_NEED : RD_NEED;
   assign enough = (lvl >= need);
   assign grant  = active && enough;
   assign refuse = active && !enough;

endmodule

// File: rtl/priv_access_filter.sv
module priv_access_filter
   import privfilt_pkg::*;
#(
   parameter int unsigned        ADDR_W      = 24,
   parameter logic [ADDR_W-1:0] RAM_BASE    = 24'hF00000,
   parameter logic [ADDR_W-1:0] RAM_SIZE    = 24'h00C000,
   parameter priv_lvl_e         RAM_RD_NEED = LVL_USER,
   parameter priv_lvl_e         RAM_WR_NEED = LVL_SUPER,
   parameter logic [ADDR_W-1:0] PWR_BASE    = 24'h800010,
   parameter logic [ADDR_W-1:0] PWR_SIZE    = 24'h000008,
   parameter priv_lvl_e         PWR_RD_NEED = LVL_MACHINE,
   parameter priv_lvl_e         PWR_WR_NEED = LVL_MACHINE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [1:0]        priv_mode,
   output logic              ram_sel,
   output logic              pwr_sel,
   output logic              dev_we,
   output logic              bus_deny
);

   localparam int unsigned NREG = 2;
   localparam int unsigned IDX_RAM = 0;
   localparam int unsigned IDX_PWR = 1;

   localparam logic [ADDR_W:0] RAM_END = {1'b0, RAM_BASE} + {1'b0, RAM_SIZE};
   localparam logic [ADDR_W:0] PWR_END = {1'b0, PWR_BASE} + {1'b0, PWR_SIZE};
   localparam bit DISJOINT = (RAM_END <= {1'b0, PWR_BASE}) ||
                             (PWR_END <= {1'b0, RAM_BASE});

   if (!DISJOINT) begin : g_bad_overlap
      $error("priv_access_filter: guarded regions must not overlap");
   end

   localparam logic [ADDR_W-1:0] BASES [NREG] = '{RAM_BASE, PWR_BASE};
   localparam logic [ADDR_W-1:0] SIZES [NREG] = '{RAM_SIZE, PWR_SIZE};
   localparam priv_lvl_e RD_NEEDS [NREG] = '{RAM_RD_NEED, PWR_RD_NEED};
   localparam priv_lvl_e WR_NEEDS [NREG] = '{RAM_WR_NEED, PWR_WR_NEED};

   priv_lvl_e        lvl;
   logic [NREG-1:0]  hit;
   logic [NREG-1:0]  grant;
   logic [NREG-1:0]  refuse;

   assign lvl = mode_to_level(priv_mode);

   for (genvar g = 0; g < NREG; g++) begin : g_region
      pf_region_match #(
         .ADDR_W (ADDR_W),
         .BASE   (BASES[g]),
         .SIZE   (SIZES[g])
      ) u_match (
         .addr (addr),
         .hit  (hit[g])
      );

      pf_rights_check #(
         .RD_NEED (RD_NEEDS[g]),
         .WR_NEED (WR_NEEDS[g])
      ) u_rights (
         .lvl    (lvl),
         .hit    (hit[g]),
         .rd     (rd_stb),
         .wr     (wr_stb),
         .grant  (grant[g]),
         .refuse (refuse[g])
      );
   end

   assign ram_sel  = grant[IDX_RAM];
   assign pwr_sel  = grant[IDX_PWR];
   assign dev_we   = wr_stb && (|grant);
   assign bus_deny = |refuse;

   // ---------------- property checks ----------------
   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_sel, pwr_sel}));                                  // R10

   AST_DENY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_deny |-> !ram_sel && !pwr_sel && !dev_we);                  // R10

   AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      dev_we |-> wr_stb && (ram_sel || pwr_sel));                     // R10

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb || wr_stb) |-> !ram_sel && !pwr_sel && !dev_we && !bus_deny); // R8

   AST_USER_RAM_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (priv_mode == 2'b00 || priv_mode == 2'b10)) |-> !ram_sel); // R4

   AST_PWR_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_sel |-> (priv_mode == 2'b11));                              // R6

   AST_RAM_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !wr_stb && hit[IDX_RAM]) |-> ram_sel && !bus_deny);  // R2

   AST_RESERVED_AS_USER: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_mode == 2'b10) |-> (lvl == LVL_USER));                    // R1

endmodule

// File: tb/priv_access_filter_test.sv
`timescale 1ns/1ps
module priv_access_filter_test;

   localparam int unsigned   AW     = 24;
   localparam logic [23:0]   RAM_B  = 24'hF00000;
   localparam logic [23:0]   RAM_S  = 24'h00C000;
   localparam logic [23:0]   PWR_B  = 24'h800010;
   localparam logic [23:0]   PWR_S  = 24'h000008;
   localparam logic [1:0]    M_U = 2'b00, M_S = 2'b01, M_R = 2'b10, M_M = 2'b11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          rd_stb = 1'b0;
   logic          wr_stb = 1'b0;
   logic [1:0]    priv_mode = 2'b00;
   logic [7:0]    wdata = 8'h00;
   logic          ram_sel, pwr_sel, dev_we, bus_deny;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;   // 125 MHz

   priv_access_filter #(
      .ADDR_W   (AW),
      .RAM_BASE (RAM_B),
      .RAM_SIZE (RAM_S),
      .PWR_BASE (PWR_B),
      .PWR_SIZE (PWR_S)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .rd_stb    (rd_stb),
      .wr_stb    (wr_stb),
      .priv_mode (priv_mode),
      .ram_sel   (ram_sel),
      .pwr_sel   (pwr_sel),
      .dev_we    (dev_we),
      .bus_deny  (bus_deny)
   );

   // bench-side devices: store whatever is written while the filter enables it
   logic [7:0] dev_mem [int];
   always @(posedge clk) begin
      if (dev_we && (ram_sel || pwr_sel)) dev_mem[int'(addr)] = wdata;
   end

   function automatic logic [3:0] model(input logic [23:0] a, input logic r,
                                        input logic w, input logic [1:0] m);
      int lvl;
      int need;
      bit in_ram, in_pwr;
      lvl    = (m == 2'b11) ? 2 : ((m == 2'b01) ? 1 : 0);
      in_ram = (int'(a) >= int'(RAM_B)) && (int'(a) < int'(RAM_B) + int'(RAM_S));
      in_pwr = (int'(a) >= int'(PWR_B)) && (int'(a) < int'(PWR_B) + int'(PWR_S));
      if (!(r || w) || !(in_ram || in_pwr)) return 4'b0000;
      need = in_pwr ? 2 : (w ? 1 : 0);
      if (lvl >= need) return {in_ram, in_pwr, w, 1'b0};
      return 4'b0001;
   endfunction

   task automatic check_out(input string tag);
      logic [3:0] exp_v, got_v;
      exp_v = model(addr, rd_stb, wr_stb, priv_mode);
      got_v = {ram_sel, pwr_sel, dev_we, bus_deny};
      total++;
      if (got_v !== exp_v) begin
         bad++;
         $display("FAIL %s addr=%h rd=%b wr=%b mode=%b got {sel_ram,sel_pwr,we,deny}=%b expected=%b",
                  tag, addr, rd_stb, wr_stb, priv_mode, got_v, exp_v);
      end
   endtask

   task automatic bus_op(input logic [23:0] a, input logic r, input logic w,
                         input logic [1:0] m, input logic [7:0] d, input string tag);
      @(posedge clk); #1;
      addr = a; rd_stb = r; wr_stb = w; priv_mode = m; wdata = d;
      @(negedge clk);
      check_out(tag);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      rd_stb = 1'b0; wr_stb = 1'b0;
   endtask

   task automatic check_mem(input logic [23:0] a, input logic [7:0] expv, input string tag);
      logic [7:0] got;
      got = dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : 8'hxx;
      total++;
      if (got !== expv) begin
         bad++;
         $display("FAIL %s readback addr=%h got=%h expected=%h", tag, a, got, expv);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // reset state: idle bus, outputs quiet (R8)
      repeat (3) @(posedge clk);
      #1; addr = RAM_B; priv_mode = M_M;
      @(negedge clk); check_out("R8 reset");
      rst_n = 1'b1;

      // R1 / R2: reads of the RAM bank from every mode code
      bus_op(RAM_B + 24'h10, 1, 0, M_U, 8'h00, "R2 user read");
      bus_op(RAM_B + 24'h10, 1, 0, M_S, 8'h00, "R2 super read");
      bus_op(RAM_B + 24'h10, 1, 0, M_M, 8'h00, "R2 machine read");
      bus_op(RAM_B + 24'h10, 1, 0, M_R, 8'h00, "R1 reserved read");

      // R3 then R4: permitted write, refused user write, readback from machine
      bus_op(RAM_B + 24'h20, 0, 1, M_S, 8'hA5, "R3 super write");
      bus_op(RAM_B + 24'h21, 0, 1, M_M, 8'h3C, "R3 machine write");
      bus_op(RAM_B + 24'h20, 0, 1, M_U, 8'h5A, "R4 user write");
      bus_op(RAM_B + 24'h21, 0, 1, M_R, 8'hFF, "R1 reserved write");
      bus_op(RAM_B + 24'h20, 1, 0, M_M, 8'h00, "R4 readback op");
      check_mem(RAM_B + 24'h20, 8'hA5, "R4");
      check_mem(RAM_B + 24'h21, 8'h3C, "R1");

      // R5 / R6: power register
      bus_op(PWR_B, 0, 1, M_M, 8'h81, "R5 machine write");
      bus_op(PWR_B, 1, 0, M_M, 8'h00, "R5 machine read");
      bus_op(PWR_B, 0, 1, M_S, 8'h00, "R6 super write");
      bus_op(PWR_B, 0, 1, M_U, 8'h00, "R6 user write");
      bus_op(PWR_B, 1, 0, M_S, 8'h00, "R6 super read");
      bus_op(PWR_B, 1, 0, M_R, 8'h00, "R6 reserved read");
      idle();
      check_mem(PWR_B, 8'h81, "R6");

      // R7: outside both regions
      bus_op(24'h000100, 1, 0, M_U, 8'h00, "R7 low read");
      bus_op(24'h400000, 0, 1, M_M, 8'h11, "R7 mid write");
      bus_op(24'hFFFFFF, 0, 1, M_S, 8'h22, "R7 top write");

      // R8: strobes low at guarded addresses
      bus_op(PWR_B, 0, 0, M_U, 8'h00, "R8 idle pwr");
      bus_op(RAM_B, 0, 0, M_S, 8'h00, "R8 idle ram");

      // R9: both strobes
      bus_op(RAM_B + 24'h30, 1, 1, M_U, 8'h77, "R9 user both");
      bus_op(RAM_B + 24'h30, 1, 1, M_S, 8'h66, "R9 super both");
      bus_op(PWR_B + 24'h1, 1, 1, M_S, 8'h55, "R9 super both pwr");

      // R11: boundaries
      bus_op(RAM_B,                1, 0, M_U, 8'h00, "R11 ram first");
      bus_op(RAM_B + RAM_S - 24'h1, 1, 0, M_U, 8'h00, "R11 ram last");
      bus_op(RAM_B - 24'h1,        1, 0, M_U, 8'h00, "R11 ram below");
      bus_op(RAM_B + RAM_S,        1, 0, M_U, 8'h00, "R11 ram past");
      bus_op(PWR_B,                1, 0, M_M, 8'h00, "R11 pwr first");
      bus_op(PWR_B + PWR_S - 24'h1, 1, 0, M_M, 8'h00, "R11 pwr last");
      bus_op(PWR_B - 24'h1,        1, 0, M_M, 8'h00, "R11 pwr below");
      bus_op(PWR_B + PWR_S,        1, 0, M_M, 8'h00, "R11 pwr past");

      // R10: mixed stimulus across boundaries and gaps, compared every cycle
      for (int i = 0; i < 400; i++) begin
         logic [23:0] a;
         case ($urandom_range(0, 5))
            0: a = RAM_B + 24'($urandom_range(0, 32'h0000BFFF));
            1: a = RAM_B + RAM_S - 24'($urandom_range(0, 2));
            2: a = RAM_B - 24'($urandom_range(0, 1));
            3: a = PWR_B + 24'($urandom_range(0, 9)) - 24'h1;
            4: a = 24'($urandom_range(0, 32'h00FFFFFF));
            default: a = PWR_B + 24'($urandom_range(0, 7));
         endcase
         bus_op(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)), "R10 mixed");
      end
      idle();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule